// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a parameterised set of sources and decides which one the processor should take next. Each source owns a sticky pending flag, an enable bit and a three-bit priority. Every cycle an arbiter scans the sources that are pending, enabled and have a non-zero priority. It picks the highest priority, and on a tie the lowest source index wins. The winner's vector number and its priority, as a four-bit level, are registered toward the processor.

The registered winner is compared with the processor's current level, which is four bits wide. Software can write the low three bits. The top bit comes from an input pin and cannot be written. An interrupt line is raised only when the winner's priority is strictly above that level. Once raised, the line, vector and level are frozen until the processor acknowledges. The acknowledge loads the winner's priority into the level register and marks an interrupt as in service. A return pulse ends the in-service state. When the nesting-disable bit is set, no new request is raised while an interrupt is in service.

A small word-addressed register port gives software access to flags, enables, priorities, the processor level and the control bit. Writes take effect on the clock edge. Reads are combinational.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on req_i[i] sets pending flag i (address 0, bit i). A write to address 0 clears exactly the flags whose data bit is 1. If a request and a clear hit the same flag in the same cycle, the flag stays set.
- R2: Enable bit i is at address 1, bit i. A pending source whose enable bit is 0 never wins.
- R3: The priority of source i is held at address 4 + i/4, bits [4*(i%4)+2 : 4*(i%4)]. A source whose priority is 0 never wins.
- R4: Among eligible sources, the highest priority wins, and on equal priority the lower index wins.
- R5: One cycle after the inputs settle, vec_o equals 8 + winner index and lvl_o equals the winner's priority with bit 3 clear. With no eligible source, both read 0.
- R6: At address 3, data bits [2:0] are writable. Bit 3 always reads the ipl3_i input and is ignored on writes. The effective processor level is the full 4-bit value.
- R7: irq_o rises one cycle after an eligible winner exists whose priority is strictly greater than the effective processor level.
- R8: Address 2, bit 0 is the nesting-disable bit. While it is 1 and an interrupt is in service (from an acknowledge until a ret_i pulse), irq_o does not rise.
- R9: While irq_o is 1 and ack_i is 0, irq_o, vec_o and lvl_o hold their values. ack_i while irq_o is 1 clears irq_o on the next edge, copies lvl_o[2:0] into the processor level and enters the in-service state.
- R10: After reset, every register reads 0 (except level bit 3, which follows ipl3_i), and irq_o, vec_o and lvl_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | N_SRC | Per-source request pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | DW | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | DW | Register read data (combinational) |
| ipl3_i | input | 1 | Read-only top bit of the processor level |
| ack_i | input | 1 | Processor acknowledge of the presented interrupt |
| ret_i | input | 1 | Return from interrupt, ends the in-service state |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector number of the latched winner |
| lvl_o | output | 4 | New priority level of the latched winner |

## Verification
The assertions check on every cycle the properties that hold at all times. Pending flags never drop unless a clear was written. A raised request always outranks the level seen in the cycle before it rose. The vector is in range whenever a request is raised. The held request stays frozen until acknowledged, and the acknowledge drops the request, loads the level and marks an interrupt in service. A request never rises while nesting is disabled and an interrupt is in service. Which source should win a given mix of flags, enables, priorities and processor levels can only be shown by the bench. It sweeps hundreds of such mixes and compares them with an arithmetic model. Its directed scenarios cover the read-only level bit, the set-versus-clear collision and the sequence of hold, acknowledge and re-request.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int PRIO_W   = 3;
  localparam int LVL_W    = PRIO_W + 1;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 8;
  localparam int SLOT_W   = 4;
  localparam int ADDR_W   = 4;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [VEC_W-1:0]  vec_t;

  typedef enum logic [ADDR_W-1:0] {
    A_FLAG  = 4'd0,
    A_EN    = 4'd1,
    A_CTRL  = 4'd2,
    A_LVL   = 4'd3,
    A_PRIO0 = 4'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int DW    = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        req_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [DW-1:0]           rd_data_o,
  input  logic                    ipl3_i,
  input  logic                    ack_take_i,
  input  prio_t                   ack_prio_i,
  input  logic                    ret_i,
  output logic [N_SRC-1:0]        flag_o,
  output logic [N_SRC-1:0]        en_o,
  output logic [N_SRC*PRIO_W-1:0] prio_o,
  output lvl_t                    cpu_lvl_o,
  output logic                    nest_dis_o,
  output logic                    busy_o
);
  localparam int SPW = DW / SLOT_W;

  // write decode
  logic wr_flag, wr_en_bank, wr_ctrl, wr_lvl;
  assign wr_flag    = wr_en_i && (wr_addr_i == A_FLAG);
  assign wr_en_bank = wr_en_i && (wr_addr_i == A_EN);
  assign wr_ctrl    = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_lvl     = wr_en_i && (wr_addr_i == A_LVL);

  // pending flags: hardware sets, software clears, set wins
  logic [N_SRC-1:0] flag_q, flag_d, flag_clr;
  logic             flag_upd;
  assign flag_clr = wr_flag ? wr_data_i[N_SRC-1:0] : '0;
  assign flag_d   = req_i | (flag_q & ~flag_clr);
  assign flag_upd = (|req_i) | wr_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= '0;
    else if (flag_upd) flag_q <= flag_d;
  end

  // enables
  logic [N_SRC-1:0] en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         en_q <= '0;
    else if (wr_en_bank) en_q <= wr_data_i[N_SRC-1:0];
  end

  // nesting disable
  logic nest_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      nest_q <= 1'b0;
    else if (wr_ctrl) nest_q <= wr_data_i[0];
  end

  // processor level, low bits; acknowledge takes precedence over software
  prio_t lvl_lo_q, lvl_lo_d;
  logic  lvl_we;
  always_comb begin
    lvl_we   = ack_take_i | wr_lvl;
    lvl_lo_d = ack_take_i ? ack_prio_i : wr_data_i[PRIO_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_lo_q <= '0;
    else if (lvl_we) lvl_lo_q <= lvl_lo_d;
  end

  // in-service state
  logic busy_q, busy_d, busy_we;
  always_comb begin
    busy_we = ack_take_i | ret_i;
    busy_d  = ack_take_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (busy_we) busy_q <= busy_d;
  end

  // per-source priority slots
  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    localparam int WORD = g / SPW;
    localparam int OFS  = (g % SPW) * SLOT_W;
    logic  slot_we;
    prio_t slot_q;

    assign slot_we = wr_en_i && (wr_addr_i == ADDR_W'(int'(A_PRIO0) + WORD));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      slot_q <= '0;
      else if (slot_we) slot_q <= wr_data_i[OFS +: PRIO_W];
    end

    assign prio_o[g*PRIO_W +: PRIO_W] = slot_q;
  end

  // read mux
  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_FLAG) rd_data_o[N_SRC-1:0]  = flag_q;
    if (rd_addr_i == A_EN)   rd_data_o[N_SRC-1:0]  = en_q;
    if (rd_addr_i == A_CTRL) rd_data_o[0]          = nest_q;
    if (rd_addr_i == A_LVL)  rd_data_o[LVL_W-1:0]  = cpu_lvl_o;
    for (int i = 0; i < N_SRC; i++) begin
      if (rd_addr_i == ADDR_W'(int'(A_PRIO0) + i / SPW))
        rd_data_o[(i % SPW) * SLOT_W +: PRIO_W] = prio_o[i*PRIO_W +: PRIO_W];
    end
  end

  assign flag_o     = flag_q;
  assign en_o       = en_q;
  assign cpu_lvl_o  = {ipl3_i, lvl_lo_q};
  assign nest_dis_o = nest_q;
  assign busy_o     = busy_q;

  // R1: a flag only drops where a clear was written
  p_flag_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_q) |=> ((~flag_q & $past(flag_q & ~flag_clr)) == '0));

  // R1: a request pulse always leaves its flag set
  p_req_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> ((flag_q & $past(req_i)) == $past(req_i)));

  // R9: acknowledge copies the winner level and enters service
  p_ack_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_take_i |=> (busy_o && (cpu_lvl_o[PRIO_W-1:0] == $past(ack_prio_i))));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]        flag_i,
  input  logic [N_SRC-1:0]        en_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    win_valid_o,
  output logic [IDX_W-1:0]        win_idx_o,
  output prio_t                   win_prio_o
);
  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = flag_i[g] && en_i[g] && (prio_i[g*PRIO_W +: PRIO_W] != '0);
  end

  // descending scan with >= : lower index overrides on ties
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_prio_o  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (prio_i[i*PRIO_W +: PRIO_W] >= win_prio_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_out.sv
module irq_out
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_valid_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  prio_t            win_prio_i,
  input  lvl_t             cpu_lvl_i,
  input  logic             nest_dis_i,
  input  logic             busy_i,
  input  logic             ack_i,
  output logic             ack_take_o,
  output logic             irq_o,
  output vec_t             vec_o,
  output lvl_t             lvl_o
);
  logic irq_q, irq_d;
  vec_t vec_q, vec_d;
  lvl_t lvl_q, lvl_d;
  logic hold, outrank, blocked;

  always_comb begin
    hold       = irq_q && !ack_i;
    ack_take_o = irq_q && ack_i;
    outrank    = win_valid_i && ({1'b0, win_prio_i} > cpu_lvl_i);
    blocked    = nest_dis_i && busy_i;

    if (hold) begin
      irq_d = 1'b1;
      vec_d = vec_q;
      lvl_d = lvl_q;
    end else if (ack_take_o) begin
      irq_d = 1'b0;
      vec_d = vec_q;
      lvl_d = lvl_q;
    end else begin
      irq_d = outrank && !blocked;
      vec_d = win_valid_i ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx_i)) : '0;
      lvl_d = win_valid_i ? {1'b0, win_prio_i} : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
    end else begin
      irq_q <= irq_d;
      vec_q <= vec_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
  assign lvl_o = lvl_q;

  // R9: presented request frozen until acknowledged
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o) && $stable(lvl_o)));

  // R9: acknowledge drops the request
  p_ack_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> !irq_o);

  // R7: a new request strictly outranks the level it was compared with
  p_outrank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (lvl_o > $past(cpu_lvl_i)));

  // R8: no new request while nesting is off and a service is open
  p_nest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !($past(nest_dis_i) && $past(busy_i)));

  // R5: raised vector lies in the source range
  p_vec_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((vec_o >= VEC_W'(VEC_BASE)) && (vec_o < VEC_W'(VEC_BASE + N_SRC))));

  // R3: a zero priority is never presented as a request
  p_lvl_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (lvl_o != '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int DW    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              ipl3_i,
  input  logic              ack_i,
  input  logic              ret_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [LVL_W-1:0]  lvl_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic                    rst_n;
  logic [N_SRC-1:0]        flag, en;
  logic [N_SRC*PRIO_W-1:0] prio;
  lvl_t                    cpu_lvl;
  logic                    nest_dis, busy, ack_take;
  logic                    win_valid;
  logic [IDX_W-1:0]        win_idx;
  prio_t                   win_prio;

  irq_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  irq_regs #(.N_SRC(N_SRC), .DW(DW)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .req_i      (req_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .ipl3_i     (ipl3_i),
    .ack_take_i (ack_take),
    .ack_prio_i (lvl_o[PRIO_W-1:0]),
    .ret_i      (ret_i),
    .flag_o     (flag),
    .en_o       (en),
    .prio_o     (prio),
    .cpu_lvl_o  (cpu_lvl),
    .nest_dis_o (nest_dis),
    .busy_o     (busy)
  );

  irq_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_arb (
    .flag_i      (flag),
    .en_i        (en),
    .prio_i      (prio),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_prio_o  (win_prio)
  );

  irq_out #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .win_valid_i (win_valid),
    .win_idx_i   (win_idx),
    .win_prio_i  (win_prio),
    .cpu_lvl_i   (cpu_lvl),
    .nest_dis_i  (nest_dis),
    .busy_i      (busy),
    .ack_i       (ack_i),
    .ack_take_o  (ack_take),
    .irq_o       (irq_o),
    .vec_o       (vec_o),
    .lvl_o       (lvl_o)
  );
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int DW  = 16;
  localparam int AD_FLAG = 0, AD_EN = 1, AD_CTRL = 2, AD_LVL = 3, AD_PRIO0 = 4;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [N-1:0]  req;
  logic          wr_en;
  logic [3:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic [3:0]    rd_addr;
  logic [DW-1:0] rd_data;
  logic          ipl3, ack, ret;
  logic          irq;
  logic [7:0]    vec;
  logic [3:0]    lvl;

  int checks = 0;
  int errors = 0;
  int prio_m [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N), .DW(DW)) i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .ipl3_i(ipl3), .ack_i(ack), .ret_i(ret),
    .irq_o(irq), .vec_o(vec), .lvl_o(lvl)
  );

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = DW'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 4'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic pulse_req(input int m);
    req = N'(m); step(); req = '0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic pulse_ret();
    ret = 1'b1; step(); ret = 1'b0;
  endtask

  task automatic set_prios();
    int d0, d1;
    d0 = 0; d1 = 0;
    for (int i = 0; i < 4; i++) d0 |= prio_m[i] << (4*i);
    for (int i = 0; i < 4; i++) d1 |= prio_m[i+4] << (4*i);
    wr(AD_PRIO0, d0);
    wr(AD_PRIO0 + 1, d1);
  endtask

  task automatic clean();
    wr(AD_FLAG, 'hFF);
    if (irq) pulse_ack();
    pulse_ret();
    wr(AD_CTRL, 0);
    wr(AD_LVL, 0);
  endtask

  task automatic model(input int fl, input int en, input int cpu,
                       output int e_irq, output int e_vec, output int e_lvl);
    int best, idx;
    best = 0; idx = -1;
    for (int i = 0; i < N; i++)
      if (fl[i] && en[i] && prio_m[i] > best) begin best = prio_m[i]; idx = i; end
    e_vec = (idx < 0) ? 0 : 8 + idx;
    e_lvl = best;
    e_irq = (idx >= 0 && best > cpu) ? 1 : 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, e_irq, e_vec, e_lvl, fl, en, cpu;
    rst_ni = 1'b0; req = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; ipl3 = 1'b0; ack = 1'b0; ret = 1'b0;
    repeat (3) step();
    rst_ni = 1'b1;
    repeat (4) step();

    // R10: reset state
    chk("R10 irq", int'(irq), 0);
    chk("R10 vec", int'(vec), 0);
    chk("R10 lvl", int'(lvl), 0);
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk("R10 reg", v, 0);
    end

    // R1: set, ignored zero clear, collision, clear
    pulse_req('h04);
    rd(AD_FLAG, v); chk("R1 set", v, 4);
    wr(AD_FLAG, 0);
    rd(AD_FLAG, v); chk("R1 zero write", v, 4);
    req = N'('h04); wr(AD_FLAG, 'h04); req = '0;
    rd(AD_FLAG, v); chk("R1 set beats clear", v, 4);
    wr(AD_FLAG, 'h04);
    rd(AD_FLAG, v); chk("R1 clear", v, 0);

    // R6: read-only top level bit
    clean();
    wr(AD_LVL, 'hF);
    rd(AD_LVL, v); chk("R6 low bits", v, 7);
    ipl3 = 1'b1;
    rd(AD_LVL, v); chk("R6 top bit", v, 15);
    for (int i = 0; i < N; i++) prio_m[i] = 0;
    prio_m[0] = 7;
    set_prios();
    wr(AD_EN, 'h01);
    pulse_req('h01);
    step(); step();
    chk("R6 masked by level 15", int'(irq), 0);
    chk("R5 vec shown", int'(vec), 8);
    ipl3 = 1'b0;
    step(); step();
    chk("R7 equal level no irq", int'(irq), 0);
    wr(AD_LVL, 6);
    step();
    chk("R7 irq above level", int'(irq), 1);
    chk("R5 lvl", int'(lvl), 7);

    // R3: zero priority never wins; R2: disabled never wins
    clean();
    for (int i = 0; i < N; i++) prio_m[i] = 0;
    prio_m[2] = 5;
    set_prios();
    wr(AD_EN, 'hFB);
    pulse_req('h06);
    step(); step();
    chk("R3 zero prio vec", int'(vec), 0);
    chk("R2 disabled irq", int'(irq), 0);
    wr(AD_EN, 'hFF);
    step();
    chk("R2 enabled vec", int'(vec), 10);
    chk("R2 enabled irq", int'(irq), 1);

    // R4: tie goes to lower index
    clean();
    for (int i = 0; i < N; i++) prio_m[i] = 0;
    prio_m[4] = 3; prio_m[6] = 3;
    set_prios();
    pulse_req('h50);
    step(); step();
    chk("R4 tie vec", int'(vec), 12);

    // R9: hold, acknowledge, re-request
    clean();
    for (int i = 0; i < N; i++) prio_m[i] = 0;
    prio_m[3] = 2; prio_m[5] = 6;
    set_prios();
    wr(AD_EN, 'hFF);
    pulse_req('h08);
    step(); step();
    chk("R9 first vec", int'(vec), 11);
    pulse_req('h20);
    step(); step();
    chk("R9 held vec", int'(vec), 11);
    chk("R9 held irq", int'(irq), 1);
    pulse_ack();
    chk("R9 ack drops irq", int'(irq), 0);
    rd(AD_LVL, v); chk("R9 level loaded", v, 2);
    step();
    chk("R9 re-request irq", int'(irq), 1);
    chk("R9 re-request vec", int'(vec), 13);

    // R8: nesting disabled holds off higher request until return
    clean();
    wr(AD_CTRL, 1);
    pulse_req('h08);
    step(); step();
    chk("R8 first irq", int'(irq), 1);
    pulse_ack();
    pulse_req('h20);
    step(); step(); step();
    chk("R8 blocked irq", int'(irq), 0);
    pulse_ret();
    step();
    chk("R8 after return irq", int'(irq), 1);
    chk("R8 after return vec", int'(vec), 13);

    // R4 R5 R7: sweep of flag/enable/priority/level mixes
    for (int k = 0; k < 512; k++) begin
      clean();
      fl  = k & 'hFF;
      en  = (k & 'h100) ? 'hFF : 'h5A;
      cpu = (k / 7) % 4;
      for (int i = 0; i < N; i++) prio_m[i] = (i * 3 + k) % 6;
      set_prios();
      wr(AD_EN, en);
      wr(AD_LVL, cpu);
      pulse_req(fl);
      step(); step();
      model(fl, en, cpu, e_irq, e_vec, e_lvl);
      chk("R7 sweep irq", int'(irq), e_irq);
      chk("R4 sweep vec", int'(vec), e_vec);
      chk("R5 sweep lvl", int'(lvl), e_lvl);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule